// File: doc/BRIEF.md
# Cascadable Prioritized Interrupt Controller

This block gathers up to 32 interrupt sources into one request line for a processor. Each source is marked at build time as edge-type or level-type. Hardware inputs pass through a synchronizer and are latched into a sticky pending register. Software can also set pending bits directly, which makes self-test possible. A pending source counts only when its enable bit is set and the nesting mask lets it through. The lowest-numbered source that meets both conditions wins and appears in the vector register. When the master enable is on, a registered request line is raised.

A mode register holds two switches. The master switch gates the request line. The hardware-recognition switch chooses between two modes. With it off, the block is in simulation mode and only software-raised bits are latched. With it on, the block is in real mode and hardware inputs are latched as well. The nesting mask resets to all ones. Software clears the bit of the source being serviced and the bits of every higher-numbered source, so that only more urgent sources can interrupt the handler.

Several controllers can be chained. A head or middle controller takes the request line of the next controller on input 31 and treats it as a level-type source. Each controller adds a fixed offset to the number it reports, so the whole chain uses one range of IDs.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, pending, enable and mode are all zero. The nesting mask (offset 8) reads 0xFFFFFFFF, the vector (offset 6) reads 0xFFFFFFFF and `irq_out` is low.
- R2: A write to offset 1 sets every pending bit whose data bit is 1, in the cycle of the write. Reading offset 1 returns the pending bits.
- R3: Hardware inputs are latched only while mode bit 1 (offset 7) is set. With that bit clear, hardware inputs have no effect on pending. A level input that rises before clock edge k shows in pending after edge k+2.
- R4: An edge-type source (EDGE_MASK bit set, bits 0..7 by default) sets pending once per rising edge. Pending stays set after the input falls. Once acknowledged, pending stays clear while the input is held high.
- R5: A level-type source that is acknowledged while its input is still high is pending again.
- R6: Offset 2 reads and writes the whole enable word. A write to offset 4 sets enable bits, and a write to offset 5 clears enable bits, where the data bit is 1. Offset 0 reads pending AND enable.
- R7: Offset 6 returns ID_BASE plus the lowest index that is pending, enabled and allowed by the nesting mask. It returns 0xFFFFFFFF when no source qualifies.
- R8: A source whose nesting mask bit (offset 8) is 0 is left out of the vector and the request, even when it is pending and enabled.
- R9: `irq_out` rises one cycle after the master bit (mode bit 0) is set while a source qualifies. It falls one cycle after either condition goes away. It stays low while the master bit is clear.
- R10: With KIND set to head or middle, input 31 is taken from `casc_in` as a level-type source and `src_in[31]` is ignored. ID_BASE is 0 for solo and head, NSRC for middle, and 2*NSRC for tail.
- R11: A write to offset 3 clears every pending bit whose data bit is 1. A hardware capture or a software set in the same cycle takes precedence over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | NSRC | Hardware interrupt sources |
| casc_in | input | 1 | Request line of the next controller in a chain |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word offset |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Combinational read data |
| irq_out | output | 1 | Registered interrupt request |

## Verification
A register write changes state at the clock edge that samples it. Read data is combinational, so a read made in the next cycle sees the new value, and `irq_out` follows one edge later. A hardware input driven before edge k reaches pending at edge k+2, because it passes two synchronizer stages first. The bench drives and samples on falling edges. It counts the exact number of falling edges from each stimulus and checks the result on both sides of the cycle in which it is due.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int RA_W = 4;

    typedef enum logic [RA_W-1:0] {
        RA_STAT = 4'd0,
        RA_PEND = 4'd1,
        RA_ENAB = 4'd2,
        RA_ACKN = 4'd3,
        RA_SETE = 4'd4,
        RA_CLRE = 4'd5,
        RA_VECT = 4'd6,
        RA_MODE = 4'd7,
        RA_LEVL = 4'd8
    } reg_addr_e;

    typedef enum logic [1:0] {
        CK_SOLO = 2'd0,
        CK_HEAD = 2'd1,
        CK_MID  = 2'd2,
        CK_TAIL = 2'd3
    } casc_kind_e;

    typedef struct packed {
        logic hw_on;
        logic master;
    } mode_t;

    function automatic int id_base(input casc_kind_e k, input int n);
        case (k)
            CK_MID:  return n;
            CK_TAIL: return 2 * n;
            default: return 0;
        endcase
    endfunction

    function automatic bit forwards_chain(input casc_kind_e k);
        return (k == CK_HEAD) || (k == CK_MID);
    endfunction

endpackage

// File: rtl/irqc_capture.sv
module irqc_capture
    import irqc_pkg::*;
#(
    parameter int              N         = 32,
    parameter int              STAGES    = 2,
    parameter logic [N-1:0]    EDGE_MASK = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] raw,
    input  logic         hw_on,
    output logic [N-1:0] hit
);

    logic [N-1:0] sync_q [STAGES];
    logic [N-1:0] prev_q;
    logic [N-1:0] s_last;

    assign s_last = sync_q[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) sync_q[s] <= '0;
            prev_q <= '0;
        end else begin
            sync_q[0] <= raw;
            for (int s = 1; s < STAGES; s++) sync_q[s] <= sync_q[s-1];
            prev_q <= s_last;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_src
        if (EDGE_MASK[i]) begin : g_edge
            assign hit[i] = hw_on & s_last[i] & ~prev_q[i];
            // R4: an edge source never captures on two cycles in a row
            a_r4_edge_single: assert property (@(posedge clk) disable iff (rst)
                hit[i] |=> !hit[i]);
        end else begin : g_level
            assign hit[i] = hw_on & s_last[i];
        end
    end

endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int N  = 32,
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr,
    input  logic [RA_W-1:0] addr,
    input  logic [DW-1:0]   wdata,
    input  logic [N-1:0]    hit,
    output logic [N-1:0]    pend_q,
    output logic [N-1:0]    en_q,
    output logic [N-1:0]    lvl_q,
    output mode_t           mode_q
);

    logic [N-1:0] sw_set;
    logic [N-1:0] ack_v;
    logic [N-1:0] wbits;

    assign wbits  = wdata[N-1:0];
    assign sw_set = (wr && addr == RA_PEND) ? wbits : '0;
    assign ack_v  = (wr && addr == RA_ACKN) ? wbits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            en_q   <= '0;
            lvl_q  <= '1;
            mode_q <= '0;
        end else begin
            pend_q <= (pend_q & ~ack_v) | hit | sw_set;
            if (wr) begin
                case (addr)
                    RA_ENAB: en_q   <= wbits;
                    RA_SETE: en_q   <= en_q | wbits;
                    RA_CLRE: en_q   <= en_q & ~wbits;
                    RA_LEVL: lvl_q  <= wbits;
                    RA_MODE: mode_q <= mode_t'(wdata[1:0]);
                    default: ;
                endcase
            end
        end
    end

    // R11: an acknowledged bit with no capture or set in that cycle is clear
    a_r11_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (pend_q & $past(ack_v & ~hit & ~sw_set)) == '0);
    // R2: a software-set bit is pending in the next cycle
    a_r2_sw_sticks: assert property (@(posedge clk) disable iff (rst)
        (pend_q & $past(sw_set)) == $past(sw_set));
    // R6: clear-enable strobe leaves those bits off
    a_r6_clre: assert property (@(posedge clk) disable iff (rst)
        $past(wr && addr == RA_CLRE) |-> ((en_q & $past(wbits)) == '0));

endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
    parameter int N   = 32,
    parameter int IDW = $clog2(N)
) (
    input  logic [N-1:0]   req,
    output logic           valid,
    output logic [IDW-1:0] id
);

    always_comb begin
        valid = 1'b0;
        id    = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                valid = 1'b1;
                id    = IDW'(i);
            end
        end
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int                NSRC      = 32,
    parameter int                DW        = 32,
    parameter int                STAGES    = 2,
    parameter logic [NSRC-1:0]   EDGE_MASK = 'hFF,
    parameter casc_kind_e        KIND      = CK_SOLO
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NSRC-1:0]    src_in,
    input  logic               casc_in,
    input  logic               bus_wr,
    input  logic [RA_W-1:0]    bus_addr,
    input  logic [DW-1:0]      bus_wdata,
    output logic [DW-1:0]      bus_rdata,
    output logic               irq_out
);

    localparam int              IDW      = $clog2(NSRC);
    localparam bit              FWD      = forwards_chain(KIND);
    localparam int              ID_BASE  = id_base(KIND, NSRC);
    localparam logic [NSRC-1:0] TOP_BIT  = NSRC'(1) << (NSRC - 1);
    localparam logic [NSRC-1:0] EFF_EDGE = FWD ? (EDGE_MASK & ~TOP_BIT) : EDGE_MASK;

    logic [NSRC-1:0] raw;
    logic [NSRC-1:0] hit;
    logic [NSRC-1:0] pend_q;
    logic [NSRC-1:0] en_q;
    logic [NSRC-1:0] lvl_q;
    mode_t           mode_q;
    logic [NSRC-1:0] eligible;
    logic            vec_valid;
    logic [IDW-1:0]  vec_id;
    logic            irq_q;

    assign raw = FWD ? {casc_in, src_in[NSRC-2:0]} : src_in;

    irqc_capture #(
        .N(NSRC), .STAGES(STAGES), .EDGE_MASK(EFF_EDGE)
    ) u_capture (
        .clk(clk), .rst(rst), .raw(raw), .hw_on(mode_q.hw_on), .hit(hit)
    );

    irqc_regs #(
        .N(NSRC), .DW(DW)
    ) u_regs (
        .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .hit(hit), .pend_q(pend_q), .en_q(en_q), .lvl_q(lvl_q), .mode_q(mode_q)
    );

    assign eligible = pend_q & en_q & lvl_q;

    irqc_prio #(
        .N(NSRC), .IDW(IDW)
    ) u_prio (
        .req(eligible), .valid(vec_valid), .id(vec_id)
    );

    always_comb begin
        case (bus_addr)
            RA_STAT: bus_rdata = DW'(pend_q & en_q);
            RA_PEND: bus_rdata = DW'(pend_q);
            RA_ENAB: bus_rdata = DW'(en_q);
            RA_VECT: bus_rdata = vec_valid ? (DW'(ID_BASE) + DW'(vec_id)) : '1;
            RA_MODE: bus_rdata = DW'(mode_q);
            RA_LEVL: bus_rdata = DW'(lvl_q);
            default: bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= mode_q.master & vec_valid;
    end

    assign irq_out = irq_q;

    // R7: the winner is eligible and nothing of higher priority is
    a_r7_lowest: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> (eligible[vec_id] &&
                       ((pend_q & en_q & lvl_q & ((NSRC'(1) << vec_id) - NSRC'(1))) == '0)));
    // R8: a masked source never wins
    a_r8_mask_respected: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> lvl_q[vec_id]);
    // R9: request only after the master switch was on
    a_r9_irq_gated: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> $past(mode_q.master));

endmodule

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prio_irq_ctrl_bench;
    import irqc_pkg::*;

    typedef struct packed {
        logic        wr;
        logic [3:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } step_t;

    localparam int NSTEP = 30;
    localparam step_t STEPS [NSTEP] = '{
        '{1'b0, 4'd8, 32'h0,        32'hFFFF_FFFF, 4'd1},
        '{1'b0, 4'd6, 32'h0,        32'hFFFF_FFFF, 4'd1},
        '{1'b0, 4'd2, 32'h0,        32'h0,         4'd1},
        '{1'b1, 4'd1, 32'h30,       32'h0,         4'd2},
        '{1'b0, 4'd1, 32'h0,        32'h30,        4'd2},
        '{1'b0, 4'd0, 32'h0,        32'h0,         4'd6},
        '{1'b0, 4'd6, 32'h0,        32'hFFFF_FFFF, 4'd7},
        '{1'b1, 4'd4, 32'h20,       32'h0,         4'd6},
        '{1'b0, 4'd2, 32'h0,        32'h20,        4'd6},
        '{1'b0, 4'd6, 32'h0,        32'h5,         4'd7},
        '{1'b1, 4'd4, 32'h10,       32'h0,         4'd6},
        '{1'b0, 4'd6, 32'h0,        32'h4,         4'd7},
        '{1'b0, 4'd0, 32'h0,        32'h30,        4'd6},
        '{1'b1, 4'd8, 32'hF,        32'h0,         4'd8},
        '{1'b0, 4'd6, 32'h0,        32'hFFFF_FFFF, 4'd8},
        '{1'b1, 4'd1, 32'h2,        32'h0,         4'd2},
        '{1'b1, 4'd4, 32'h2,        32'h0,         4'd6},
        '{1'b0, 4'd6, 32'h0,        32'h1,         4'd8},
        '{1'b0, 4'd1, 32'h0,        32'h32,        4'd2},
        '{1'b1, 4'd8, 32'hFFFF_FFFF, 32'h0,        4'd8},
        '{1'b1, 4'd3, 32'h2,        32'h0,         4'd11},
        '{1'b0, 4'd1, 32'h0,        32'h30,        4'd11},
        '{1'b0, 4'd6, 32'h0,        32'h4,         4'd7},
        '{1'b1, 4'd5, 32'h10,       32'h0,         4'd6},
        '{1'b0, 4'd2, 32'h0,        32'h22,        4'd6},
        '{1'b0, 4'd6, 32'h0,        32'h5,         4'd7},
        '{1'b1, 4'd2, 32'h0,        32'h0,         4'd6},
        '{1'b0, 4'd0, 32'h0,        32'h0,         4'd6},
        '{1'b1, 4'd3, 32'hFFFF_FFFF, 32'h0,        4'd11},
        '{1'b0, 4'd1, 32'h0,        32'h0,         4'd11}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic        casc_b = 1'b0;
    logic        wr_a = 1'b0;
    logic        wr_b = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rd_a;
    logic [31:0] rd_b;
    logic        irq_a;
    logic        irq_b;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;
    logic [31:0] v;

    always #10 clk = ~clk;

    prio_irq_ctrl u_prio_irq_ctrl (
        .clk(clk), .rst(rst), .src_in(src_a), .casc_in(1'b0),
        .bus_wr(wr_a), .bus_addr(addr), .bus_wdata(wdata),
        .bus_rdata(rd_a), .irq_out(irq_a)
    );

    prio_irq_ctrl #(.KIND(CK_MID)) u_prio_irq_ctrl_mid (
        .clk(clk), .rst(rst), .src_in(src_b), .casc_in(casc_b),
        .bus_wr(wr_b), .bus_addr(addr), .bus_wdata(wdata),
        .bus_rdata(rd_b), .irq_out(irq_b)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input bit sel, input logic [3:0] a, input logic [31:0] d);
        addr  = a;
        wdata = d;
        if (sel) wr_b = 1'b1; else wr_a = 1'b1;
        @(negedge clk);
        wr_a = 1'b0;
        wr_b = 1'b0;
    endtask

    task automatic rd(input bit sel, input logic [3:0] a, output logic [31:0] r);
        addr = a;
        #1;
        r = sel ? rd_b : rd_a;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        step(3);
        rst = 1'b0;
        // R1 reset state
        chk("R1 irq after reset", {31'b0, irq_a}, 32'h0);
        rd(0, 4'd7, v); chk("R1 mode after reset", v, 32'h0);

        // register-level table, simulation mode
        for (int i = 0; i < NSTEP; i++) begin
            if (STEPS[i].wr) wr(0, STEPS[i].addr, STEPS[i].data);
            else begin
                rd(0, STEPS[i].addr, v);
                chk($sformatf("R%0d table step %0d", STEPS[i].req, i), v, STEPS[i].exp);
            end
        end

        // R9 request gating and timing
        wr(0, 4'd2, 32'h8);
        wr(0, 4'd1, 32'h8);
        step(3);
        chk("R9 master off keeps irq low", {31'b0, irq_a}, 32'h0);
        wr(0, 4'd7, 32'h1);
        chk("R9 irq not yet up", {31'b0, irq_a}, 32'h0);
        step(1);
        chk("R9 irq up one cycle later", {31'b0, irq_a}, 32'h1);
        wr(0, 4'd3, 32'h8);
        step(1);
        chk("R9 irq drops after ack", {31'b0, irq_a}, 32'h0);
        rd(0, 4'd6, v); chk("R7 vector empty", v, 32'hFFFF_FFFF);

        // R3 simulation mode ignores hardware
        src_a[20] = 1'b1;
        step(5);
        rd(0, 4'd1, v); chk("R3 hw ignored in sim mode", v, 32'h0);
        src_a[20] = 1'b0;
        step(4);
        wr(0, 4'd7, 32'h3);
        src_a[20] = 1'b1;
        step(2);
        rd(0, 4'd1, v); chk("R3 level not yet captured", v & 32'h0010_0000, 32'h0);
        step(1);
        rd(0, 4'd1, v); chk("R3 level captured at k+2", v & 32'h0010_0000, 32'h0010_0000);

        // R5 level re-pends while high
        wr(0, 4'd3, 32'h0010_0000);
        rd(0, 4'd1, v); chk("R5 level re-pends", v & 32'h0010_0000, 32'h0010_0000);
        src_a[20] = 1'b0;
        step(4);
        wr(0, 4'd3, 32'h0010_0000);
        rd(0, 4'd1, v); chk("R5 level cleared once low", v, 32'h0);

        // R4 edge source
        src_a[3] = 1'b1;
        step(4);
        rd(0, 4'd1, v); chk("R4 edge captured", v, 32'h8);
        wr(0, 4'd3, 32'h8);
        step(4);
        rd(0, 4'd1, v); chk("R4 held high stays clear", v, 32'h0);
        src_a[3] = 1'b0;
        step(4);
        rd(0, 4'd1, v); chk("R4 fall adds nothing", v, 32'h0);
        src_a[3] = 1'b1;
        step(4);
        rd(0, 4'd1, v); chk("R4 new edge captured", v, 32'h8);

        // R10 cascade middle controller
        wr(1, 4'd7, 32'h3);
        wr(1, 4'd2, 32'hFFFF_FFFF);
        src_b[31] = 1'b1;
        step(4);
        rd(1, 4'd1, v); chk("R10 src_in31 ignored", v, 32'h0);
        rd(1, 4'd6, v); chk("R10 vector empty", v, 32'hFFFF_FFFF);
        casc_b = 1'b1;
        step(4);
        rd(1, 4'd6, v); chk("R10 chained id", v, 32'd63);
        wr(1, 4'd3, 32'h8000_0000);
        rd(1, 4'd1, v); chk("R10 chain input is level", v, 32'h8000_0000);
        chk("R10 irq from chain", {31'b0, irq_b}, 32'h1);
        wr(1, 4'd1, 32'h1);
        rd(1, 4'd6, v); chk("R10 id base on source 0", v, 32'd32);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule